// File: doc/BRIEF.md
# Register-Mapped SPI Word Host

This block is a single-word SPI host behind a small memory-mapped register bank. Software picks one of eight chip-select lines and asserts it, programs clock polarity, clock phase, word size and the bit order of each direction, then writes a word to the transmit register. The block shifts that word out on MOSI while it collects the word returned on MISO. When the last bit is in, it raises a completion cause flag that software polls and clears before the next word.

Each half period of SCK is paced by a one-cycle enable pulse, `sck_en`, from an external rate generator, so this block has no divider of its own. A timing field chooses when MISO is captured. It can capture at the sampling edge or one system clock later, and the later point helps at the fastest SCK rate in mode 3. The received word stays readable, zero-extended, until the next word completes.

Top module: `spi_word_host`

## Requirements
- R1: After reset, all `spi_cs_n` lines are high, SCK and MOSI are low, and every register reads 0, except the timing register, which reads 0x40 (sample field = 1).
- R2: In the control register (offset 0x00), bit 0 asserts a chip select and bits 4:2 hold its index. On the clock after a single write, `spi_cs_n[index]` is low only when bit 0 is 1, and at no time is more than one line low.
- R3: Configuration bit 5 (offset 0x04) selects 16-bit words when set and 8-bit words when clear. A word produces exactly 16 or 8 SCK periods respectively.
- R4: Configuration bit 11 is CPOL, the SCK idle level. Bit 12 is CPHA. With CPHA=0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Configuration bit 13 sends the transmit word least significant bit first, and bit 14 assembles the received word least significant bit first. Each direction is independent, and a clear bit means most significant bit first.
- R6: A write to offset 0x08 while idle starts a word. The low 8 or 16 bits of the written value are sent.
- R7: When a word completes, the cause register (offset 0x10) reads 1. A write of 0 to it clears it.
- R8: Offset 0x0C returns the received word zero-extended to 32 bits. It keeps that value until the next word completes.
- R9: Timing bits 7:6 (offset 0x18) select the MISO capture point. The value 2 captures one system clock after the sampling edge. Any other value captures at the sampling edge.
- R10: While no word is in flight, SCK equals CPOL and MOSI is 0.
- R11: A write to offset 0x08 while a word is in flight is ignored. It sends nothing and does not set the cause flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data valid on the next cycle |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sck_en | input | 1 | Half-period pacing pulse for SCK |
| spi_miso | input | 1 | Serial data from the target |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
Several internal faults each show at the ports within one word. A wrong edge counter or a wrongly latched word size shows as a wrong number of SCK periods, seen by the bench as a target at the final edge. A misrouted sampling edge, bit order or capture delay corrupts the received word at the first poll of the data-in register. A stale busy flag shows either as a second word shifted after an ignored write or as SCK that is not parked at CPOL once the cause flag reads set. A bad chip-select decode appears on `spi_cs_n` one clock after the control write.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // Register byte offsets
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_CFG   = 'h04;
  localparam int unsigned OFS_DOUT  = 'h08;
  localparam int unsigned OFS_DIN   = 'h0C;
  localparam int unsigned OFS_CAUSE = 'h10;
  localparam int unsigned OFS_TIME  = 'h18;

  // Field positions
  localparam int unsigned CS_EN_BIT   = 0;
  localparam int unsigned CS_IDX_LSB  = 2;
  localparam int unsigned WIDE_BIT    = 5;
  localparam int unsigned CPOL_BIT    = 11;
  localparam int unsigned CPHA_BIT    = 12;
  localparam int unsigned TX_LSB_BIT  = 13;
  localparam int unsigned RX_LSB_BIT  = 14;
  localparam int unsigned SAMP_LSB    = 6;

  localparam logic [1:0] SAMPLE_DFLT = 2'd1;
  localparam logic [1:0] SAMPLE_LATE = 2'd2;

  typedef struct packed {
    logic rx_lsb;
    logic tx_lsb;
    logic cpha;
    logic cpol;
    logic wide;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic [NUM_CS-1:0] cs_n,
  output xfer_cfg_t         cfg,
  output logic              late_sample,
  output logic              start,
  output logic [WORD_W-1:0] tx_word
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic             cs_en;
  logic [IDX_W-1:0] cs_idx;
  logic [1:0]       samp_sel;
  logic             cause;
  logic [NUM_CS-1:0] cs_hit;
  logic [DATA_W-1:0] rd_mux;

  logic wr_ctrl, wr_cfg, wr_dout, wr_cause, wr_time;
  assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_cfg   = reg_we && (reg_addr == ADDR_W'(OFS_CFG));
  assign wr_dout  = reg_we && (reg_addr == ADDR_W'(OFS_DOUT));
  assign wr_cause = reg_we && (reg_addr == ADDR_W'(OFS_CAUSE));
  assign wr_time  = reg_we && (reg_addr == ADDR_W'(OFS_TIME));

  // Per-line decode of the incoming control word
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_hit[g] = reg_wdata[CS_EN_BIT] &&
                       (reg_wdata[CS_IDX_LSB +: IDX_W] == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_en    <= 1'b0;
      cs_idx   <= '0;
      cs_n     <= '1;
      cfg      <= '0;
      samp_sel <= SAMPLE_DFLT;
      cause    <= 1'b0;
      start    <= 1'b0;
      tx_word  <= '0;
    end else begin
      start <= 1'b0;
      if (wr_ctrl) begin
        cs_en  <= reg_wdata[CS_EN_BIT];
        cs_idx <= reg_wdata[CS_IDX_LSB +: IDX_W];
        cs_n   <= ~cs_hit;
      end
      if (wr_cfg) begin
        cfg.wide   <= reg_wdata[WIDE_BIT];
        cfg.cpol   <= reg_wdata[CPOL_BIT];
        cfg.cpha   <= reg_wdata[CPHA_BIT];
        cfg.tx_lsb <= reg_wdata[TX_LSB_BIT];
        cfg.rx_lsb <= reg_wdata[RX_LSB_BIT];
      end
      if (wr_time) samp_sel <= reg_wdata[SAMP_LSB +: 2];
      if (wr_dout && !busy && !start) begin
        start   <= 1'b1;
        tx_word <= reg_wdata[WORD_W-1:0];
      end
      if (done) cause <= 1'b1;
      else if (wr_cause && (reg_wdata == '0)) cause <= 1'b0;
    end
  end

  assign late_sample = (samp_sel == SAMPLE_LATE);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(OFS_CTRL): begin
        rd_mux[CS_EN_BIT] = cs_en;
        rd_mux[CS_IDX_LSB +: IDX_W] = cs_idx;
      end
      ADDR_W'(OFS_CFG): begin
        rd_mux[WIDE_BIT]   = cfg.wide;
        rd_mux[CPOL_BIT]   = cfg.cpol;
        rd_mux[CPHA_BIT]   = cfg.cpha;
        rd_mux[TX_LSB_BIT] = cfg.tx_lsb;
        rd_mux[RX_LSB_BIT] = cfg.rx_lsb;
      end
      ADDR_W'(OFS_DIN):   rd_mux[WORD_W-1:0] = rx_word;
      ADDR_W'(OFS_CAUSE): rd_mux[0] = cause;
      ADDR_W'(OFS_TIME):  rd_mux[SAMP_LSB +: 2] = samp_sel;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_host_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_en,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  xfer_cfg_t         cfg,
  input  logic              late_sample,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * NARROW_W - 1);

  logic [WORD_W-1:0] tx_sr, rx_sr, tx_norm, rx_fill, rx_out;
  logic [CNT_W-1:0]  edge_cnt, last_edge;
  logic fin, dly_pend;
  logic wide_l, cpol_l, cpha_l, rxlsb_l, late_l;
  logic sample_edge;

  // Put the first wire bit at the top of the shift register
  always_comb begin
    tx_norm = '0;
    if (cfg.wide) begin
      for (int i = 0; i < WORD_W; i++)
        tx_norm[i] = cfg.tx_lsb ? tx_word[WORD_W-1-i] : tx_word[i];
    end else begin
      for (int i = 0; i < NARROW_W; i++)
        tx_norm[WORD_W-NARROW_W+i] = cfg.tx_lsb ? tx_word[NARROW_W-1-i] : tx_word[i];
    end
  end

  // Received bits enter at bit 0; the first one ends at the word's top
  always_comb begin
    rx_fill = dly_pend ? {rx_sr[WORD_W-2:0], miso} : rx_sr;
    rx_out  = '0;
    if (wide_l) begin
      for (int i = 0; i < WORD_W; i++)
        rx_out[i] = rxlsb_l ? rx_fill[WORD_W-1-i] : rx_fill[i];
    end else begin
      for (int i = 0; i < NARROW_W; i++)
        rx_out[i] = rxlsb_l ? rx_fill[NARROW_W-1-i] : rx_fill[i];
    end
  end

  assign last_edge   = wide_l ? LAST_WIDE : LAST_NARROW;
  assign sample_edge = (!edge_cnt[0]) ^ cpha_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; fin <= 1'b0; dly_pend <= 1'b0;
      sck <= 1'b0; mosi <= 1'b0; edge_cnt <= '0;
      tx_sr <= '0; rx_sr <= '0; rx_word <= '0;
      wide_l <= 1'b0; cpol_l <= 1'b0; cpha_l <= 1'b0; rxlsb_l <= 1'b0; late_l <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck  <= cfg.cpol;
        mosi <= 1'b0;
        if (start) begin
          busy <= 1'b1; fin <= 1'b0; dly_pend <= 1'b0; edge_cnt <= '0; rx_sr <= '0;
          wide_l <= cfg.wide; cpol_l <= cfg.cpol; cpha_l <= cfg.cpha;
          rxlsb_l <= cfg.rx_lsb; late_l <= late_sample;
          if (cfg.cpha) begin
            tx_sr <= tx_norm;
          end else begin
            mosi  <= tx_norm[WORD_W-1];
            tx_sr <= tx_norm << 1;
          end
        end
      end else begin
        if (dly_pend) begin
          rx_sr    <= {rx_sr[WORD_W-2:0], miso};
          dly_pend <= 1'b0;
        end
        if (fin) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= rx_out;
          mosi    <= 1'b0;
          sck     <= cpol_l;
        end else if (sck_en) begin
          sck      <= ~sck;
          edge_cnt <= edge_cnt + 1'b1;
          if (sample_edge) begin
            if (late_l) dly_pend <= 1'b1;
            else        rx_sr    <= {rx_sr[WORD_W-2:0], miso};
          end else if (edge_cnt != last_edge) begin
            mosi  <= tx_sr[WORD_W-1];
            tx_sr <= tx_sr << 1;
          end
          if (edge_cnt == last_edge) fin <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_word_host.sv
module spi_word_host
  import spi_host_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NUM_CS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_en,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n
);
  xfer_cfg_t         cfg_q;
  logic              late_q, start_q, eng_busy, eng_done;
  logic [WORD_W-1:0] tx_q, rx_q;

  spi_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .NUM_CS(NUM_CS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(eng_busy), .done(eng_done), .rx_word(rx_q),
    .cs_n(spi_cs_n), .cfg(cfg_q), .late_sample(late_q),
    .start(start_q), .tx_word(tx_q)
  );

  spi_shift_core #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) u_core (
    .clk(clk), .rst(rst), .sck_en(sck_en),
    .start(start_q), .tx_word(tx_q), .cfg(cfg_q), .late_sample(late_q),
    .miso(spi_miso), .busy(eng_busy), .done(eng_done), .rx_word(rx_q),
    .sck(spi_sck), .mosi(spi_mosi)
  );

endmodule

// File: rtl/spi_word_host_chk.sv
module spi_word_host_chk #(
  parameter int NUM_CS   = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              mosi,
  input logic              cpol,
  input logic              busy,
  input logic              done,
  input logic              start
);
  logic       sck_d;
  logic [7:0] tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      tog   <= '0;
    end else begin
      sck_d <= sck;
      if (!busy)             tog <= '0;
      else if (sck != sck_d) tog <= tog + 1'b1;
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol && !mosi));

  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (tog == 8'(2 * WORD_W) || tog == 8'(2 * NARROW_W)));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

bind spi_word_host spi_word_host_chk #(
  .NUM_CS(NUM_CS), .WORD_W(WORD_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .cpol(cfg_q.cpol), .busy(eng_busy), .done(eng_done), .start(start_q)
);

// File: tb/spi_word_host_bench.sv
`timescale 1ns/1ps
module spi_word_host_bench;
  logic        clk = 0, rst = 1;
  logic        reg_we = 0, reg_re = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        sck_en = 0, spi_miso = 0;
  logic        spi_sck, spi_mosi;
  logic [7:0]  spi_cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  spi_word_host u_spi_word_host (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_en(sck_en), .spi_miso(spi_miso), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always #5 clk = ~clk;

  // Pacing pulse every fourth cycle
  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    sck_en <= (div == 0);
  end

  // Target model: reacts to SCK edges half a cycle after they appear
  bit          s_on = 0, s_cpha = 0, s_late = 0;
  int          s_edge = 0, s_n = 8;
  logic [15:0] s_word = 0, m_acc = 0;
  logic        prev_sck = 0;
  always @(negedge clk) begin
    if (s_on && spi_sck != prev_sck) begin
      if (((s_edge % 2) == 0) ^ s_cpha) begin
        m_acc = {m_acc[14:0], spi_mosi};
        if (s_late) spi_miso = ~spi_miso;
      end else if (!s_cpha) begin
        if ((s_edge + 1) / 2 < s_n) spi_miso = s_word[s_n - 1 - (s_edge + 1) / 2];
      end else begin
        spi_miso = s_word[s_n - 1 - s_edge / 2];
      end
      s_edge++;
    end
    prev_sck = spi_sck;
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  function automatic logic [15:0] revn(logic [15:0] x, int n);
    logic [15:0] r = 0;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction

  function automatic logic [31:0] cfg_word(bit w, bit pol, bit pha, bit tl, bit rl);
    return (32'(w) << 5) | (32'(pol) << 11) | (32'(pha) << 12) |
           (32'(tl) << 13) | (32'(rl) << 14);
  endfunction

  task automatic wait_cause(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      rd(5'h10, d);
      if (d != 0) begin ok = 1; break; end
    end
  endtask

  task automatic xfer(bit w, bit pol, bit pha, bit tl, bit rl, logic [1:0] tsel,
                      logic [15:0] txd, logic [15:0] sw, bit late);
    int n = w ? 16 : 8;
    logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
    logic [15:0] exp_rx, exp_m;
    logic [31:0] d;
    bit ok;
    wr(5'h04, cfg_word(w, pol, pha, tl, rl));
    wr(5'h18, 32'(tsel) << 6);
    @(negedge clk);
    s_word = sw & mask; s_n = n; s_cpha = pha; s_late = late; s_edge = 0; m_acc = 0;
    spi_miso = pha ? 1'b0 : s_word[n-1];
    s_on = 1;
    wr(5'h08, {16'hA5A5, txd});
    wait_cause(ok);
    check(ok, "R7 cause set after word", 32'(ok), 1);
    s_on = 0;
    exp_rx = rl ? revn(s_word, n) : s_word;
    if (late && tsel == 2'd2) exp_rx = ~exp_rx & mask;
    exp_m = tl ? revn(txd, n) : (txd & mask);
    rd(5'h0C, d);
    check(d == {16'h0, exp_rx}, "R4 R5 R9 received word", d, {16'h0, exp_rx});
    check((m_acc & mask) == exp_m, "R5 R6 MOSI bits seen by target", 32'(m_acc & mask), 32'(exp_m));
    check(s_edge == 2 * n, "R3 SCK edge count", s_edge, 2 * n);
    wr(5'h10, 0);
    rd(5'h10, d);
    check(d == 0, "R7 cause cleared by writing 0", d, 0);
    check(spi_sck == pol && spi_mosi == 0, "R10 idle lines", {spi_sck, spi_mosi}, {pol, 1'b0});
    rd(5'h0C, d);
    check(d == {16'h0, exp_rx}, "R8 data in held", d, {16'h0, exp_rx});
  endtask

  initial begin
    #(180000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int e0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 8'hFF, "R1 cs_n reset", spi_cs_n, 8'hFF);
    check(spi_sck == 0 && spi_mosi == 0, "R1 sck/mosi reset", {spi_sck, spi_mosi}, 0);
    rd(5'h18, d); check(d == 32'h40, "R1 timing reset", d, 32'h40);
    rd(5'h04, d); check(d == 0, "R1 config reset", d, 0);
    rd(5'h10, d); check(d == 0, "R1 cause reset", d, 0);
    rd(5'h0C, d); check(d == 0, "R1 data in reset", d, 0);

    // R2 chip selects
    wr(5'h00, (5 << 2) | 1); @(negedge clk);
    check(spi_cs_n == ~(8'h1 << 5), "R2 select 5", spi_cs_n, ~(8'h1 << 5));
    rd(5'h00, d); check(d == 32'h15, "R2 control readback", d, 32'h15);
    wr(5'h00, (2 << 2) | 1); @(negedge clk);
    check(spi_cs_n == ~(8'h1 << 2), "R2 move to 2 in one write", spi_cs_n, ~(8'h1 << 2));
    wr(5'h00, (7 << 2)); @(negedge clk);
    check(spi_cs_n == 8'hFF, "R2 index without assert", spi_cs_n, 8'hFF);

    // Directed corners
    wr(5'h00, (3 << 2) | 1);
    xfer(1, 1, 1, 0, 0, 2'd1, 16'hC3A5, 16'h5AF0, 0);
    xfer(0, 0, 0, 1, 0, 2'd1, 16'h0081, 16'h00C4, 0);
    xfer(0, 1, 0, 0, 1, 2'd1, 16'h00F2, 16'h0013, 0);
    // R9 late capture point
    xfer(1, 1, 1, 0, 0, 2'd2, 16'h1234, 16'hBEEF, 1);
    xfer(1, 1, 1, 0, 0, 2'd1, 16'h1234, 16'hBEEF, 1);
    xfer(0, 0, 0, 0, 0, 2'd2, 16'h0055, 16'h00A6, 1);

    // Random words
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r = $urandom;
      wr(5'h00, (32'(r[18:16]) << 2) | 1);
      xfer(r[0], r[1], r[2], r[3], r[4], r[5] ? 2'd2 : 2'd1,
           16'($urandom), 16'($urandom), 0);
    end

    // R11 write while busy is ignored
    wr(5'h04, cfg_word(1, 0, 0, 0, 0));
    wr(5'h18, 32'h40);
    @(negedge clk);
    s_word = 16'h0F0F; s_n = 16; s_cpha = 0; s_late = 0; s_edge = 0; m_acc = 0;
    spi_miso = s_word[15]; s_on = 1;
    wr(5'h08, 32'h0000_9C3E);
    wr(5'h08, 32'h0000_FFFF);
    wait_cause(ok);
    check(ok, "R11 first word completes", 32'(ok), 1);
    check(m_acc == 16'h9C3E, "R11 second write not sent", m_acc, 16'h9C3E);
    wr(5'h10, 0);
    e0 = s_edge;
    repeat (300) @(negedge clk);
    rd(5'h10, d); check(d == 0, "R11 cause not set again", d, 0);
    check(s_edge == e0, "R11 no extra SCK edges", s_edge, e0);
    s_on = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule